// File: doc/BRIEF.md
# Packet-Aware Pixel Transform Stage

This block is an in-line stage for a packetised video stream carried on a ready/valid handshake. Every packet is framed by a start marker and an end marker on its beats. The first beat of a packet is always a header. The low bits of that header tell whether the packet holds picture samples or something else, such as control or format information. The stage applies a fixed per-channel pixel operation, chosen by a parameter, to the body beats of picture packets only. Headers, beats of every other packet type, and beats that arrive outside any packet all leave the stage bit-for-bit unchanged.

Every accepted beat is written into a small register-based buffer. The buffer's head entry drives the output, so all outputs come from flops and a stalled beat stays frozen until it is taken. Upstream ready depends only on how full the buffer is. The stage therefore never forms a combinational path from downstream ready back to upstream ready, yet it still moves one beat per clock when the sink never stalls.

Top module: `pix_pkt_xform`

## Requirements
- R1: After synchronous reset, out_valid is 0 and in_ready is 1.
- R2: A beat with in_sop set is a header and is forwarded with its data unchanged, whatever the packet type.
- R3: The packet type is the low 4 bits of the header data. Value 4'h0 marks a picture packet, and any other value marks a non-picture packet. The bits above these 4 do not matter.
- R4: In a picture packet, every beat after the header is transformed. With the default invert mode, each output bit is the complement of the input bit.
- R5: Every beat of a non-picture packet is forwarded unchanged.
- R6: The sop and eop markers leave the stage on the same beat as their data.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_sop and out_eop hold their values.
- R8: in_ready is 1 exactly when the buffer has a free entry. Beats leave in the order they were accepted, with none lost and none duplicated.
- R9: A beat accepted while the buffer is empty appears on the output one clock later.
- R10: When out_ready stays 1, in_ready stays 1, so one beat per clock passes through.
- R11: After an end-of-packet beat is accepted, the packet state clears, and a beat without in_sop is forwarded unchanged until the next header.
- R12: In gain mode, each 8-bit channel of a picture beat is doubled and saturates at 8'hFF. Channel 0 is the least significant byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Stage can accept a beat |
| in_data | input | CH_W*NUM_CH | Upstream beat data |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | CH_W*NUM_CH | Output beat data |
| out_sop | output | 1 | Output start marker |
| out_eop | output | 1 | Output end marker |

## Verification
The stream under test mixes picture and non-picture packets of lengths one to six beats. Some headers carry nonzero upper bits over a zero type code, which separates a full-width type compare from the 4-bit one. Stray beats placed after an end marker show whether the packet flag clears, and single-beat packets show whether a header ever reaches the transform. Random valid and random ready expose holding, ordering and loss faults under backpressure. A run with ready held high tells a buffer that keeps full throughput from one that stalls every other beat. A second instance in gain mode, given a saturating channel and a non-saturating one, separates the two transform variants.

// File: rtl/pix_pkt_pkg.sv
package pix_pkt_pkg;

   typedef enum logic [1:0] {
      XF_INVERT = 2'd0,
      XF_GAIN2  = 2'd1,
      XF_NONE   = 2'd2
   } xform_e;

endpackage

// File: rtl/pix_classify.sv
module pix_classify #(
   parameter int DATA_W     = 24,
   parameter int TYPE_W     = 4,
   parameter int VIDEO_CODE = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc,
   input  logic              sop,
   input  logic              eop,
   input  logic [DATA_W-1:0] data,
   output logic              is_pixel
);

   if (TYPE_W > DATA_W) begin : g_bad_type_w
      $error("pix_classify: TYPE_W exceeds DATA_W");
   end

   logic in_pkt_q;
   logic vid_q;

   assign is_pixel = !sop && in_pkt_q && vid_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         in_pkt_q <= 1'b0;
         vid_q    <= 1'b0;
      end else if (acc) begin
         if (sop) begin
            in_pkt_q <= !eop;
            vid_q    <= (data[TYPE_W-1:0] == TYPE_W'(VIDEO_CODE));
         end else if (eop) begin
            in_pkt_q <= 1'b0;
            vid_q    <= 1'b0;
         end
      end
   end

   assert_flag_clear_R11: assert property (@(posedge clk) disable iff (rst)
      (acc && eop) |=> !is_pixel);

   assert_hdr_bypass_R2: assert property (@(posedge clk) disable iff (rst)
      (acc && sop && eop) |=> !in_pkt_q);

endmodule

// File: rtl/pix_xform.sv
module pix_xform
   import pix_pkt_pkg::*;
#(
   parameter int     CH_W   = 8,
   parameter int     NUM_CH = 3,
   parameter xform_e XFORM  = XF_INVERT
) (
   input  logic [CH_W*NUM_CH-1:0] din,
   output logic [CH_W*NUM_CH-1:0] dout
);

   if (CH_W < 2) begin : g_bad_ch_w
      $error("pix_xform: CH_W must be at least 2");
   end
   if (NUM_CH < 1) begin : g_bad_num_ch
      $error("pix_xform: NUM_CH must be at least 1");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [CH_W-1:0] cin;
      assign cin = din[c*CH_W +: CH_W];
      if (XFORM == XF_INVERT) begin : g_inv
         assign dout[c*CH_W +: CH_W] = ~cin;
      end else if (XFORM == XF_GAIN2) begin : g_gain
         assign dout[c*CH_W +: CH_W] = cin[CH_W-1] ? {CH_W{1'b1}} : {cin[CH_W-2:0], 1'b0};
      end else begin : g_pass
         assign dout[c*CH_W +: CH_W] = cin;
      end
   end

endmodule

// File: rtl/pix_obuf.sv
module pix_obuf #(
   parameter int W     = 26,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic [W-1:0] wdata,
   output logic         full,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] rdata
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pix_obuf: DEPTH below 2 cannot sustain one beat per clock");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] cnt;
   logic             pop;

   assign full      = (cnt == CNT_W'(DEPTH));
   assign out_valid = (cnt != '0);
   assign pop       = out_valid && out_ready;
   assign rdata     = mem[rd_ptr];

   function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wr_ptr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= nxt(wr_ptr);
         if (pop)  rd_ptr <= nxt(rd_ptr);
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
      push |-> (cnt < CNT_W'(DEPTH)));

   assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(rdata)));

endmodule

// File: rtl/pix_pkt_xform.sv
module pix_pkt_xform
   import pix_pkt_pkg::*;
#(
   parameter int     CH_W       = 8,
   parameter int     NUM_CH     = 3,
   parameter int     TYPE_W     = 4,
   parameter int     VIDEO_CODE = 0,
   parameter int     BUF_DEPTH  = 2,
   parameter xform_e XFORM      = XF_INVERT
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [CH_W*NUM_CH-1:0] in_data,
   input  logic                   in_sop,
   input  logic                   in_eop,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [CH_W*NUM_CH-1:0] out_data,
   output logic                   out_sop,
   output logic                   out_eop
);

   localparam int DATA_W = CH_W * NUM_CH;
   localparam int BEAT_W = DATA_W + 2;

   logic              acc;
   logic              is_pixel;
   logic              full;
   logic [DATA_W-1:0] xf_data;
   logic [BEAT_W-1:0] wbeat, rbeat;

   assign in_ready = !full;
   assign acc      = in_valid && in_ready;

   pix_classify #(
      .DATA_W    (DATA_W),
      .TYPE_W    (TYPE_W),
      .VIDEO_CODE(VIDEO_CODE)
   ) u_cls (
      .clk     (clk),
      .rst     (rst),
      .acc     (acc),
      .sop     (in_sop),
      .eop     (in_eop),
      .data    (in_data),
      .is_pixel(is_pixel)
   );

   pix_xform #(
      .CH_W  (CH_W),
      .NUM_CH(NUM_CH),
      .XFORM (XFORM)
   ) u_xf (
      .din (in_data),
      .dout(xf_data)
   );

   assign wbeat = {in_sop, in_eop, is_pixel ? xf_data : in_data};

   pix_obuf #(
      .W    (BEAT_W),
      .DEPTH(BUF_DEPTH)
   ) u_buf (
      .clk      (clk),
      .rst      (rst),
      .push     (acc),
      .wdata    (wbeat),
      .full     (full),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .rdata    (rbeat)
   );

   assign out_sop  = rbeat[BEAT_W-1];
   assign out_eop  = rbeat[BEAT_W-2];
   assign out_data = rbeat[DATA_W-1:0];

   assert_fill_latency_R9: assert property (@(posedge clk) disable iff (rst)
      (acc && !out_valid) |=> out_valid);

   assert_empty_ready_R8: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> in_ready);

   assert_marker_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> ($stable(out_sop) && $stable(out_eop)));

endmodule

// File: tb/sim_pix_pkt_xform.sv
`timescale 1ns/1ps
module sim_pix_pkt_xform;
   import pix_pkt_pkg::*;

   typedef struct packed {
      logic        s;
      logic        e;
      logic [23:0] d;
   } beat_t;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst;
   logic        in_valid, in_ready, in_sop, in_eop;
   logic [23:0] in_data;
   logic        out_valid, out_ready, out_sop, out_eop;
   logic [23:0] out_data;

   logic        g_valid, g_ready, g_sop, g_eop;
   logic [23:0] g_data;
   logic        g_ovalid, g_osop, g_oeop;
   logic [23:0] g_odata;

   pix_pkt_xform u0 (
      .clk(clk), .rst(rst),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_sop(in_sop), .in_eop(in_eop),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sop(out_sop), .out_eop(out_eop)
   );

   pix_pkt_xform #(.XFORM(XF_GAIN2)) u1 (
      .clk(clk), .rst(rst),
      .in_valid(g_valid), .in_ready(g_ready), .in_data(g_data),
      .in_sop(g_sop), .in_eop(g_eop),
      .out_valid(g_ovalid), .out_ready(1'b1), .out_data(g_odata),
      .out_sop(g_osop), .out_eop(g_oeop)
   );

   int    errors = 0;
   int    checks = 0;
   int    cyc    = 0;
   beat_t stim[$];
   beat_t expq[$];
   bit    m_in  = 1'b0;
   bit    m_vid = 1'b0;

   task automatic check(input bit ok, input string req, input logic [25:0] act, input logic [25:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic beat_t model(input beat_t b);
      beat_t r = b;
      if (b.s) begin
         m_vid = (b.d[3:0] == 4'h0);
         m_in  = !b.e;
      end else begin
         if (m_in && m_vid) r.d = ~b.d;
         if (b.e) m_in = 1'b0;
      end
      return r;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic add_packets(input int n);
      for (int p = 0; p < n; p++) begin
         bit    vid = ($urandom % 2) == 0;
         int    len = 1 + ($urandom % 6);
         beat_t b;
         b.d = ($urandom & 24'hFFFFF0) | (vid ? 24'h0 : 24'(1 + ($urandom % 15)));
         b.s = 1'b1;
         b.e = (len == 1);
         stim.push_back(b);
         for (int i = 1; i < len; i++) begin
            b.d = 24'($urandom);
            b.s = 1'b0;
            b.e = (i == len - 1);
            stim.push_back(b);
         end
         if ((p % 5) == 2) begin
            b.d = 24'($urandom);
            b.s = 1'b0;
            b.e = 1'b0;
            stim.push_back(b);
         end
      end
   endtask

   task automatic run(input bit stress);
      int    idx = 0;
      bit    p_stall = 1'b0;
      bit    p_fill  = 1'b0;
      beat_t p_out;
      beat_t ob;
      beat_t ex;
      while (idx < stim.size() || expq.size() != 0) begin
         @(negedge clk);
         if (!in_valid || in_ready) begin
            if (idx < stim.size() && (stress || ($urandom % 4) != 0)) begin
               in_valid = 1'b1;
               {in_sop, in_eop, in_data} = stim[idx];
            end else begin
               in_valid = 1'b0;
            end
         end
         out_ready = stress ? 1'b1 : (($urandom % 3) != 0);
         #1;
         ob = {out_sop, out_eop, out_data};
         if (p_stall)
            check(out_valid && ob == p_out, "R7 hold under stall", {out_valid, ob[24:0]}, {1'b1, p_out[24:0]});
         if (p_fill)
            check(out_valid == 1'b1, "R9 one-cycle latency", 26'(out_valid), 26'd1);
         if (stress)
            check(in_ready == 1'b1, "R10 full throughput", 26'(in_ready), 26'd1);
         if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
               check(1'b0, "R8 extra beat", ob, 26'h0);
            end else begin
               ex = expq.pop_front();
               check(ob == ex, "R2 R4 R5 R6 R11 beat content/order", ob, ex);
            end
         end
         p_fill = in_valid && in_ready && !out_valid;
         if (in_valid && in_ready) begin
            expq.push_back(model(stim[idx]));
            idx++;
         end
         p_stall = out_valid && !out_ready;
         p_out   = ob;
      end
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      check(!out_valid && expq.size() == 0, "R8 no lost or extra beats", 26'(out_valid), 26'd0);
      stim.delete();
   endtask

   initial begin
      beat_t b;
      rst = 1'b1;
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
      out_ready = 1'b0;
      g_valid = 1'b0; g_sop = 1'b0; g_eop = 1'b0; g_data = '0;
      void'($urandom(32'd12345));
      repeat (4) @(negedge clk);
      rst = 1'b0;
      #1;
      check(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset state", {out_valid, in_ready}, 26'b01);

      // R12 gain-mode instance, directed
      @(negedge clk);
      g_valid = 1'b1; g_sop = 1'b1; g_eop = 1'b0; g_data = 24'hABCDE0;
      @(negedge clk);
      g_sop = 1'b0; g_eop = 1'b1; g_data = 24'h10907F;
      #1;
      check({g_ovalid, g_osop, g_odata} == {2'b11, 24'hABCDE0}, "R12 header untouched in gain mode",
            {g_ovalid, g_osop, g_odata}, {2'b11, 24'hABCDE0});
      @(negedge clk);
      g_valid = 1'b0;
      #1;
      check({g_ovalid, g_oeop, g_odata} == {2'b11, 24'h20FFFE}, "R12 gain doubles and saturates",
            {g_ovalid, g_oeop, g_odata}, {2'b11, 24'h20FFFE});

      // R3: header with upper bits set over a zero type code is picture
      b.s = 1'b1; b.e = 1'b0; b.d = 24'hF0F0F0; stim.push_back(b);
      b.s = 1'b0; b.e = 1'b1; b.d = 24'h123456; stim.push_back(b);
      // R3/R5: type 4'h1 is non-picture
      b.s = 1'b1; b.e = 1'b0; b.d = 24'h000001; stim.push_back(b);
      b.s = 1'b0; b.e = 1'b1; b.d = 24'h654321; stim.push_back(b);
      // R11: stray beat after end of picture packet
      b.s = 1'b1; b.e = 1'b1; b.d = 24'h000000; stim.push_back(b);
      b.s = 1'b0; b.e = 1'b0; b.d = 24'h0F0F0F; stim.push_back(b);
      add_packets(60);
      run(1'b0);

      // R10 sustained stream with sink always ready
      b.s = 1'b1; b.e = 1'b0; b.d = 24'h000010; stim.push_back(b);
      for (int i = 0; i < 30; i++) begin
         b.s = 1'b0; b.e = (i == 29); b.d = 24'($urandom);
         stim.push_back(b);
      end
      run(1'b1);

      add_packets(40);
      run(1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule